// File: doc/BRIEF.md
# Ping-Pong Process/Reconfigure Scheduler

This controller runs a chain of algorithm stages on two processing elements that take turns. Element 1, the odd element, runs stages 1, 3, 5 and so on; element 0, the even element, runs stages 2, 4, 6 and so on. While one element executes stage k, the scheduler asks the other element to load its configuration for stage k+1. Only one stage executes at any moment. The saving comes from hiding reconfiguration behind execution, not from running stages in parallel.

Two shared buffers pass data from stage to stage, and their roles follow the running element. The element with index e reads buffer e and writes the other buffer, so every stage reads what the stage before it wrote. A run begins with a start pulse that carries the number of stages. The scheduler first configures the odd element on its own. It then runs stages back to back, starting each one on the cycle after both the previous stage's completion and the waiting element's configuration completion have arrived. A one-cycle done flag marks the end of the run. The algorithm logic, the configuration loader and the buffer memories sit outside this block and connect through the handshake ports.

Top module: `pingpong_sched`

## Requirements
- R1: When `start_i` is sampled while idle with a non-zero `stage_count_i`, the next cycle raises `cfg_req_o[1]` only, with `pe_run_o` at zero. No element runs until `cfg_done_i[1]` has been sampled.
- R2: Odd stage numbers run on element 1 (`pe_run_o[1]`) and even stage numbers on element 0 (`pe_run_o[0]`). A raised `pe_run_o[e]` stays high until `pe_done_i[e]` is sampled, and drops on the next cycle.
- R3: At most one bit of `pe_run_o` is high in any cycle. `stage_o` shows the number of the stage that is running, counted from 1.
- R4: In the cycle in which stage k's run bit rises, if k is less than the stage count, the request `cfg_req_o` of the other element rises in that same cycle. If k equals the count, that request stays low.
- R5: Stage k+1's run bit rises exactly one cycle after the later of two sampled events: the completion of stage k and the configuration completion of stage k+1's element. The order in which the two events arrive, or their arrival in the same cycle, does not change this.
- R6: While element e runs, `src_buf_o` equals e and `dst_buf_o` equals the other index.
- R7: After the last stage's completion is sampled, `all_done_o` is high for exactly one cycle, the next one. In that cycle `cfg_req_o` and `pe_run_o` are zero, and `busy_o` is low from then on.
- R8: With a stage count of 1, element 0 is neither requested for configuration nor run.
- R9: A start pulse sampled while busy has no effect on the run in progress, including its stage count. A start pulse with a stage count of 0 leaves the block idle.
- R10: After reset, `pe_run_o`, `cfg_req_o`, `all_done_o`, `busy_o`, `stage_o` and `src_buf_o` are 0 and `dst_buf_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| stage_count_i | input | CNT_W | Number of stages to run, captured together with the start pulse |
| pe_run_o | output | 2 | Per-element execute request, held until that element completes |
| pe_done_i | input | 2 | Per-element execution complete pulse |
| cfg_req_o | output | 2 | Per-element reconfigure request, held until that element finishes loading |
| cfg_done_i | input | 2 | Per-element reconfiguration complete pulse |
| src_buf_o | output | 1 | Index of the buffer the running element reads |
| dst_buf_o | output | 1 | Index of the buffer the running element writes |
| stage_o | output | CNT_W | Current stage number (0 after reset) |
| busy_o | output | 1 | A run is in progress |
| all_done_o | output | 1 | One-cycle pulse after the last stage completes |

## Verification
The assertions assume that the responders behave: an element signals completion only while its run or configuration request is raised, and a completion pulse lasts one cycle. The block ignores a completion pulse that arrives with no request pending, so such a pulse is also harmless. The bench's responders follow this rule. Each one waits until it sees its request, counts its own latency, pulses completion for one cycle and then falls silent. By giving the execution and configuration responders different latencies, the bench makes each completion arrive second in turn, and also makes both arrive in the same cycle.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;
  localparam int NPE     = 2;
  localparam int ODD_PE  = 1;
  localparam int EVEN_PE = 0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRIME,
    ST_EXEC
  } sched_state_t;
endpackage

// File: rtl/pe_channel.sv
module pe_channel (
  input  logic clk,
  input  logic rst,
  input  logic run_set,
  input  logic cfg_set,
  input  logic done_i,
  input  logic cfg_done_i,
  output logic run_q,
  output logic cfg_q,
  output logic run_fin,
  output logic cfg_fin
);
  assign run_fin = run_q & done_i;
  assign cfg_fin = cfg_q & cfg_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cfg_q <= 1'b0;
    end else begin
      if (run_set)      run_q <= 1'b1;
      else if (run_fin) run_q <= 1'b0;
      if (cfg_set)      cfg_q <= 1'b1;
      else if (cfg_fin) cfg_q <= 1'b0;
    end
  end

  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run_q && !done_i |=> run_q);

  // R2
  run_drop_chk: assert property (@(posedge clk) disable iff (rst)
    run_q && done_i |=> !run_q);
endmodule

// File: rtl/join_tracker.sv
module join_tracker (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic arm_clr,
  input  logic preset_b,
  input  logic a_ev,
  input  logic b_ev,
  output logic fire
);
  logic a_seen, b_seen;

  assign fire = en & (a_seen | a_ev) & (b_seen | b_ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_seen <= 1'b0;
      b_seen <= 1'b0;
    end else if (arm_clr) begin
      a_seen <= 1'b0;
      b_seen <= preset_b;
    end else if (en) begin
      a_seen <= a_seen | a_ev;
      b_seen <= b_seen | b_ev;
    end
  end

  // R5
  join_wait_chk: assert property (@(posedge clk) disable iff (rst)
    en && !arm_clr && !a_seen && !a_ev |=> !a_seen);
endmodule

// File: rtl/stage_tracker.sv
module stage_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] count_in,
  output logic [CNT_W-1:0] stage_q,
  output logic [CNT_W-1:0] count_q,
  output logic             is_last,
  output logic             has_follow,
  output logic             multi
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] stage_ext, count_ext;

  assign stage_ext  = {1'b0, stage_q};
  assign count_ext  = {1'b0, count_q};
  assign is_last    = (stage_q == count_q);
  assign has_follow = (stage_ext + EXT_W'(2)) <= count_ext;
  assign multi      = count_q > CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      count_q <= '0;
    end else if (load) begin
      stage_q <= CNT_W'(1);
      count_q <= count_in;
    end else if (adv) begin
      stage_q <= stage_q + CNT_W'(1);
    end
  end

  // R3
  stage_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv && !load |=> stage_q == $past(stage_q) + CNT_W'(1));
endmodule

// File: rtl/buffer_router.sv
module buffer_router (
  input  logic clk,
  input  logic rst,
  input  logic set_odd,
  input  logic flip,
  output logic active_q,
  output logic src_q,
  output logic dst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      src_q    <= 1'b0;
      dst_q    <= 1'b1;
    end else if (set_odd) begin
      active_q <= 1'b1;
      src_q    <= 1'b1;
      dst_q    <= 1'b0;
    end else if (flip) begin
      active_q <= ~active_q;
      src_q    <= ~active_q;
      dst_q    <= active_q;
    end
  end

  // R6
  buf_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    src_q != dst_q);
endmodule

// File: rtl/pingpong_sched.sv
module pingpong_sched
  import pingpong_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] stage_count_i,
  output logic [1:0]       pe_run_o,
  input  logic [1:0]       pe_done_i,
  output logic [1:0]       cfg_req_o,
  input  logic [1:0]       cfg_done_i,
  output logic             src_buf_o,
  output logic             dst_buf_o,
  output logic [CNT_W-1:0] stage_o,
  output logic             busy_o,
  output logic             all_done_o
);
  sched_state_t state_q, state_d;

  logic [NPE-1:0] run_set, cfg_set, run_q, cfg_q, run_fin, cfg_fin;
  logic           j_clr, j_pre, fire, ld, adv, set_odd, flip, fin;
  logic           act, idle_pe;
  logic           is_last, has_follow, multi;
  logic [CNT_W-1:0] stage_q, count_q;
  logic           done_q;

  for (genvar g = 0; g < NPE; g++) begin : g_pe
    pe_channel u_ch (
      .clk        (clk),
      .rst        (rst),
      .run_set    (run_set[g]),
      .cfg_set    (cfg_set[g]),
      .done_i     (pe_done_i[g]),
      .cfg_done_i (cfg_done_i[g]),
      .run_q      (run_q[g]),
      .cfg_q      (cfg_q[g]),
      .run_fin    (run_fin[g]),
      .cfg_fin    (cfg_fin[g])
    );
  end

  stage_tracker #(.CNT_W(CNT_W)) u_stage (
    .clk        (clk),
    .rst        (rst),
    .load       (ld),
    .adv        (adv),
    .count_in   (stage_count_i),
    .stage_q    (stage_q),
    .count_q    (count_q),
    .is_last    (is_last),
    .has_follow (has_follow),
    .multi      (multi)
  );

  buffer_router u_buf (
    .clk      (clk),
    .rst      (rst),
    .set_odd  (set_odd),
    .flip     (flip),
    .active_q (act),
    .src_q    (src_buf_o),
    .dst_q    (dst_buf_o)
  );

  assign idle_pe = ~act;

  join_tracker u_join (
    .clk      (clk),
    .rst      (rst),
    .en       (state_q == ST_EXEC),
    .arm_clr  (j_clr),
    .preset_b (j_pre),
    .a_ev     (run_fin[act]),
    .b_ev     (cfg_fin[idle_pe]),
    .fire     (fire)
  );

  always_comb begin
    state_d = state_q;
    run_set = '0;
    cfg_set = '0;
    j_clr   = 1'b0;
    j_pre   = 1'b0;
    ld      = 1'b0;
    adv     = 1'b0;
    set_odd = 1'b0;
    flip    = 1'b0;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && stage_count_i != '0) begin
          ld              = 1'b1;
          cfg_set[ODD_PE] = 1'b1;
          state_d         = ST_PRIME;
        end
      end
      ST_PRIME: begin
        if (cfg_fin[ODD_PE]) begin
          run_set[ODD_PE] = 1'b1;
          set_odd         = 1'b1;
          j_clr           = 1'b1;
          if (multi) cfg_set[EVEN_PE] = 1'b1;
          else       j_pre            = 1'b1;
          state_d         = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (fire) begin
          if (is_last) begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            adv              = 1'b1;
            flip             = 1'b1;
            j_clr            = 1'b1;
            run_set[idle_pe] = 1'b1;
            if (has_follow) cfg_set[act] = 1'b1;
            else            j_pre        = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign pe_run_o   = run_q;
  assign cfg_req_o  = cfg_q;
  assign stage_o    = stage_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign all_done_o = done_q;

  // R3
  single_run_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pe_run_o));

  // R2
  odd_parity_chk: assert property (@(posedge clk) disable iff (rst)
    pe_run_o[1] |-> stage_o[0]);

  // R2
  even_parity_chk: assert property (@(posedge clk) disable iff (rst)
    pe_run_o[0] |-> !stage_o[0]);

  // R6
  src_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (pe_run_o != 2'b00) |-> src_buf_o == pe_run_o[1]);

  // R1
  prime_only_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_PRIME |-> pe_run_o == 2'b00 && cfg_req_o == 2'b10);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    all_done_o |=> !all_done_o);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    all_done_o |-> cfg_req_o == 2'b00 && pe_run_o == 2'b00 && !busy_o);

  // R8
  single_stage_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && count_q == CNT_W'(1) |-> !cfg_req_o[0] && !pe_run_o[0]);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && start_i |=> $stable(count_q));
endmodule

// File: tb/test_pingpong_sched.sv
`timescale 1ns/1ps
module test_pingpong_sched;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] stage_count_i = '0;
  logic [1:0]       pe_run_o, cfg_req_o, pe_done_i, cfg_done_i;
  logic             src_buf_o, dst_buf_o, busy_o, all_done_o;
  logic [CNT_W-1:0] stage_o;

  logic ex_done[2];
  logic cf_done[2];
  int   ex_lat[2];
  int   cf_lat[2];

  assign pe_done_i  = {ex_done[1], ex_done[0]};
  assign cfg_done_i = {cf_done[1], cf_done[0]};

  pingpong_sched #(.CNT_W(CNT_W)) i_pingpong_sched (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .stage_count_i (stage_count_i),
    .pe_run_o      (pe_run_o),
    .pe_done_i     (pe_done_i),
    .cfg_req_o     (cfg_req_o),
    .cfg_done_i    (cfg_done_i),
    .src_buf_o     (src_buf_o),
    .dst_buf_o     (dst_buf_o),
    .stage_o       (stage_o),
    .busy_o        (busy_o),
    .all_done_o    (all_done_o)
  );

  always #2.5 clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Handshake responders
  for (genvar g = 0; g < 2; g++) begin : g_resp
    initial begin
      ex_done[g] = 1'b0;
      forever begin
        @(negedge clk);
        if (!rst && pe_run_o[g]) begin
          repeat (ex_lat[g] - 1) @(negedge clk);
          ex_done[g] = 1'b1;
          @(negedge clk);
          ex_done[g] = 1'b0;
        end
      end
    end
    initial begin
      cf_done[g] = 1'b0;
      forever begin
        @(negedge clk);
        if (!rst && cfg_req_o[g]) begin
          repeat (cf_lat[g] - 1) @(negedge clk);
          cf_done[g] = 1'b1;
          @(negedge clk);
          cf_done[g] = 1'b0;
        end
      end
    end
  end

  // Monitor, sampled shortly after each falling edge
  int cyc = 0;
  int last_exec_cyc = 0;
  int last_cfg_cyc[2];
  int runs[2];
  int cfgs[2];
  int dones = 0;
  int cnt_exp = 0;
  logic [1:0] prev_run = '0, prev_cfg = '0;
  logic prev_done = 1'b0;

  initial begin
    last_cfg_cyc[0] = 0; last_cfg_cyc[1] = 0;
    forever begin
      @(negedge clk);
      #1;
      cyc++;
      if (!rst) begin
        for (int e = 0; e < 2; e++) begin
          if (ex_done[e] && pe_run_o[e]) last_exec_cyc = cyc;
          if (cf_done[e] && cfg_req_o[e]) last_cfg_cyc[e] = cyc;
        end
        for (int e = 0; e < 2; e++) begin
          if (pe_run_o[e] && !prev_run[e]) begin
            int later;
            runs[e]++;
            chk(int'(stage_o[0]) == e, "R2", "element parity of stage", e, int'(stage_o[0]));
            chk(src_buf_o == e[0] && dst_buf_o != e[0], "R6", "src buffer", int'(src_buf_o), e);
            later = (last_exec_cyc > last_cfg_cyc[e]) ? last_exec_cyc : last_cfg_cyc[e];
            chk(cyc == later + 1, "R5", "run start cycle", cyc, later + 1);
            if (int'(stage_o) < cnt_exp)
              chk(cfg_req_o[1-e] && !prev_cfg[1-e], "R4", "other element cfg request", int'(cfg_req_o[1-e]), 1);
            else
              chk(!cfg_req_o[1-e], "R4", "no cfg request on last stage", int'(cfg_req_o[1-e]), 0);
          end
          if (cfg_req_o[e] && !prev_cfg[e]) cfgs[e]++;
        end
        if (pe_run_o == 2'b11) chk(1'b0, "R3", "both elements running", 3, 1);
        if (all_done_o) begin
          dones++;
          chk(cyc == last_exec_cyc + 1, "R7", "done cycle", cyc, last_exec_cyc + 1);
          chk(cfg_req_o == 2'b00 && pe_run_o == 2'b00, "R7", "quiet at done", int'(cfg_req_o), 0);
          if (prev_done) chk(1'b0, "R7", "done longer than one cycle", 2, 1);
        end
      end
      prev_run  = pe_run_o;
      prev_cfg  = cfg_req_o;
      prev_done = all_done_o;
    end
  end

  task automatic set_lat(input int e0, input int e1, input int c0, input int c1);
    ex_lat[0] = e0; ex_lat[1] = e1; cf_lat[0] = c0; cf_lat[1] = c1;
  endtask

  task automatic launch(input int n);
    runs[0] = 0; runs[1] = 0; cfgs[0] = 0; cfgs[1] = 0; dones = 0;
    cnt_exp = n;
    @(negedge clk);
    stage_count_i = CNT_W'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    // R1: only the odd element is asked to configure
    chk(cfg_req_o == 2'b10 && pe_run_o == 2'b00, "R1", "first request", int'(cfg_req_o), 2);
  endtask

  task automatic await_finish(input string tag);
    int t = 0;
    while (!all_done_o && t < 5000) begin
      @(negedge clk);
      #1;
      t++;
    end
    chk(t < 5000, "R7", {tag, " completion timeout"}, t, 0);
  endtask

  task automatic verify_totals(input int n, input string tag);
    repeat (3) @(negedge clk);
    #1;
    chk(runs[1] == (n + 1) / 2, "R2", {tag, " odd element runs"}, runs[1], (n + 1) / 2);
    chk(runs[0] == n / 2, "R2", {tag, " even element runs"}, runs[0], n / 2);
    chk(cfgs[1] == (n + 1) / 2, "R4", {tag, " odd element cfg"}, cfgs[1], (n + 1) / 2);
    chk(cfgs[0] == n / 2, "R4", {tag, " even element cfg"}, cfgs[0], n / 2);
    chk(dones == 1, "R7", {tag, " done pulses"}, dones, 1);
    chk(!busy_o, "R7", {tag, " busy after done"}, int'(busy_o), 0);
    chk(int'(stage_o) == n, "R3", {tag, " final stage"}, int'(stage_o), n);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10
    chk(pe_run_o == 0 && cfg_req_o == 0, "R10", "handshakes after reset", int'({pe_run_o, cfg_req_o}), 0);
    chk(!all_done_o && !busy_o && stage_o == 0, "R10", "status after reset", int'(stage_o), 0);
    chk(src_buf_o == 1'b0 && dst_buf_o == 1'b1, "R10", "buffers after reset", int'({src_buf_o, dst_buf_o}), 1);
  endtask

  task automatic t_exec_slow;
    set_lat(7, 6, 2, 2);
    launch(4);
    await_finish("exec-late");
    verify_totals(4, "exec-late");
  endtask

  task automatic t_cfg_slow;
    set_lat(2, 2, 8, 5);
    launch(5);
    // R1: nothing runs while the odd element is still loading
    repeat (3) @(negedge clk);
    #1;
    chk(pe_run_o == 2'b00, "R1", "no run before cfg done", int'(pe_run_o), 0);
    await_finish("cfg-late");
    verify_totals(5, "cfg-late");
  endtask

  task automatic t_same_cycle;
    set_lat(4, 4, 4, 4);
    launch(3);
    await_finish("tie");
    verify_totals(3, "tie");
  endtask

  task automatic t_single;
    // R8
    set_lat(3, 3, 3, 3);
    launch(1);
    await_finish("single");
    verify_totals(1, "single");
    chk(runs[0] == 0 && cfgs[0] == 0, "R8", "even element untouched", runs[0] + cfgs[0], 0);
  endtask

  task automatic t_busy_start;
    // R9
    set_lat(5, 5, 3, 3);
    launch(3);
    repeat (6) @(negedge clk);
    stage_count_i = CNT_W'(6);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    await_finish("busy-start");
    verify_totals(3, "R9 busy-start");
  endtask

  task automatic t_zero_count;
    // R9
    @(negedge clk);
    stage_count_i = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    #1;
    chk(!busy_o && cfg_req_o == 0 && pe_run_o == 0, "R9", "zero count start", int'(busy_o), 0);
  endtask

  initial begin
    set_lat(2, 2, 2, 2);
    t_reset();
    t_exec_slow();
    t_cfg_slow();
    t_same_cycle();
    t_single();
    t_busy_start();
    t_zero_count();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule